// File: doc/BRIEF.md
# Scroll Address Counter Unit

This block keeps the video-memory address that a tile-based picture generator walks while it fetches a frame. It holds two 15-bit words: a working address that the fetch logic reads, and a staging address that the rest of the chip loads with the scroll position it wants. Each word is split into a column (coarse X, bits 4:0), a tile row (coarse Y, bits 9:5), a horizontal page bit (bit 10), a vertical page bit (bit 11) and a pixel row within the tile (fine Y, bits 14:12).

The unit watches the raster position, given as a line number and a dot number, together with a rendering-enable input. On rendering lines it steps the column once per tile, steps the pixel row at the end of the visible fetches, and carries that into the tile row, which wraps at the bottom of a page and flips the vertical page. After each line it restores the horizontal part of the working address from the staging word. During the line before the frame it restores the vertical part as well. With rendering off, the working address holds still.

Top module: `scroll_addr_unit`

## Requirements
- R1: A synchronous active-high reset clears both the working address `v_addr` and the staging word to zero.
- R2: When `t_wr_en` is high at a clock edge, the staging word takes `t_wr_data`. A copy into `v_addr` at that same edge uses the staging word as it was before the write.
- R3: On a rendering line (lines 0 to 239, and line 261) with rendering enabled, coarse X (bits 4:0) increments at every dot that is a multiple of 8 from 8 to 256 and from 328 to 336. When coarse X goes from 31 to 0, bit 10 toggles.
- R4: On a rendering line with rendering enabled, fine Y (bits 14:12) increments at dot 256 when it is below 7.
- R5: At that dot, fine Y at 7 becomes 0 and coarse Y (bits 9:5) advances. Coarse Y at 29 wraps to 0 and toggles bit 11.
- R6: Coarse Y at 31 that advances wraps to 0 and leaves bit 11 unchanged.
- R7: At dot 257 of a rendering line with rendering enabled, bits 4:0 and bit 10 of `v_addr` take the staging word's values. The other bits keep their values.
- R8: On line 261 with rendering enabled, at every dot from 280 to 304 inclusive, bits 14:12, 11 and 9:5 of `v_addr` take the staging word's values. The other bits keep their values.
- R9: While `render_en` is low, `v_addr` does not change, whatever the raster position.
- R10: On lines 240 to 260, `v_addr` does not change, even at dots 8, 256 or 257.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| render_en | input | 1 | Rendering enable. Every update of the working address needs it high |
| scanline | input | 9 | Current raster line |
| dot | input | 9 | Current dot within the line |
| t_wr_en | input | 1 | Load strobe for the staging word |
| t_wr_data | input | 15 | New staging word value |
| v_addr | output | 15 | Working video address |

## Verification
Every update is decided by the line, dot and enable values present at one clock edge, and it appears on `v_addr` right after that edge. The address is a single register, so the result lags the stimulus by exactly one cycle. The bench drives each raster position on the falling edge and reads `v_addr` shortly after the next rising edge, before the next position is driven. A staging-word write takes effect at the same edge, so its effect on a copy only shows at the first copy dot after the write. The bench writes the staging word in a quiet cycle before that copy, except in one row that checks that a copy in the same cycle as a write uses the old value.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

    localparam int ADDR_W = 15;
    localparam int COL_W  = 5;
    localparam int ROW_W  = 5;
    localparam int FINE_W = 3;

    // Tile row after which the vertical page flips.
    localparam logic [ROW_W-1:0]  ROW_LAST = ROW_W'(29);
    localparam logic [FINE_W-1:0] FINE_MAX = '1;

    // Field layout of the working and staging words (MSB first).
    typedef struct packed {
        logic [FINE_W-1:0] fine_y;
        logic              page_y;
        logic              page_x;
        logic [ROW_W-1:0]  coarse_y;
        logic [COL_W-1:0]  coarse_x;
    } vaddr_t;

    // One-cycle update requests decoded from the raster position.
    typedef struct packed {
        logic step_x;
        logic step_y;
        logic load_x;
        logic load_y;
    } strobe_t;

    function automatic vaddr_t step_column(input vaddr_t a);
        vaddr_t r;
        r = a;
        r.coarse_x = a.coarse_x + 1'b1;
        if (a.coarse_x == '1) begin
            r.page_x = ~a.page_x;
        end
        return r;
    endfunction

    function automatic vaddr_t step_row(input vaddr_t a);
        vaddr_t r;
        r = a;
        if (a.fine_y != FINE_MAX) begin
            r.fine_y = a.fine_y + 1'b1;
        end else begin
            r.fine_y = '0;
            if (a.coarse_y == ROW_LAST) begin
                r.coarse_y = '0;
                r.page_y   = ~a.page_y;
            end else begin
                // Rows past the last one roll over naturally with no page flip.
                r.coarse_y = a.coarse_y + 1'b1;
            end
        end
        return r;
    endfunction

    function automatic vaddr_t take_horizontal(input vaddr_t a, input vaddr_t src);
        vaddr_t r;
        r = a;
        r.coarse_x = src.coarse_x;
        r.page_x   = src.page_x;
        return r;
    endfunction

    function automatic vaddr_t take_vertical(input vaddr_t a, input vaddr_t src);
        vaddr_t r;
        r = a;
        r.fine_y   = src.fine_y;
        r.page_y   = src.page_y;
        r.coarse_y = src.coarse_y;
        return r;
    endfunction

endpackage

// File: rtl/scroll_event_decode.sv
module scroll_event_decode
    import scroll_pkg::*;
#(
    parameter int LINE_W         = 9,
    parameter int DOT_W          = 9,
    parameter int VISIBLE_LINES  = 240,
    parameter int PRE_LINE       = 261,
    parameter int TILE_PIXELS    = 8,
    parameter int FETCH_FIRST    = 8,
    parameter int FETCH_LAST     = 256,
    parameter int PREFETCH_FIRST = 328,
    parameter int PREFETCH_LAST  = 336,
    parameter int ROW_STEP_DOT   = 256,
    parameter int COL_LOAD_DOT   = 257,
    parameter int ROW_LOAD_FIRST = 280,
    parameter int ROW_LOAD_LAST  = 304
) (
    input  logic              render_en,
    input  logic [LINE_W-1:0] scanline,
    input  logic [DOT_W-1:0]  dot,
    output strobe_t           strobe
);

    localparam int TILE_BITS = $clog2(TILE_PIXELS);
    localparam int NUM_WIN   = 2;

    localparam logic [LINE_W-1:0] VIS_END   = LINE_W'(VISIBLE_LINES);
    localparam logic [LINE_W-1:0] PRE_IDX   = LINE_W'(PRE_LINE);
    localparam logic [DOT_W-1:0]  Y_DOT     = DOT_W'(ROW_STEP_DOT);
    localparam logic [DOT_W-1:0]  X_LD_DOT  = DOT_W'(COL_LOAD_DOT);
    localparam logic [DOT_W-1:0]  Y_LD_LO   = DOT_W'(ROW_LOAD_FIRST);
    localparam logic [DOT_W-1:0]  Y_LD_HI   = DOT_W'(ROW_LOAD_LAST);

    logic render_line;
    logic pre_line;
    logic tile_edge;
    logic [NUM_WIN-1:0] in_win;

    assign pre_line    = (scanline == PRE_IDX);
    assign render_line = (scanline < VIS_END) || pre_line;
    assign tile_edge   = (dot[TILE_BITS-1:0] == '0);

    // One comparator pair per fetch window.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [DOT_W-1:0] LO = DOT_W'((w == 0) ? FETCH_FIRST : PREFETCH_FIRST);
        localparam logic [DOT_W-1:0] HI = DOT_W'((w == 0) ? FETCH_LAST  : PREFETCH_LAST);
        assign in_win[w] = (dot >= LO) && (dot <= HI);
    end

    logic active;
    assign active = render_en && render_line;

    always_comb begin
        strobe        = '0;
        strobe.step_x = active && tile_edge && (|in_win);
        strobe.step_y = active && (dot == Y_DOT);
        strobe.load_x = active && (dot == X_LD_DOT);
        strobe.load_y = render_en && pre_line && (dot >= Y_LD_LO) && (dot <= Y_LD_HI);
    end

endmodule

// File: rtl/scroll_temp_reg.sv
module scroll_temp_reg
    import scroll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output vaddr_t            t_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else if (wr_en) begin
            t_q <= vaddr_t'(wr_data);
        end
    end

endmodule

// File: rtl/scroll_vaddr_next.sv
module scroll_vaddr_next
    import scroll_pkg::*;
(
    input  vaddr_t  v_q,
    input  vaddr_t  t_q,
    input  strobe_t strobe,
    output vaddr_t  v_d
);

    vaddr_t col_part;
    vaddr_t row_part;

    // The horizontal and vertical updates touch disjoint bits, so they are
    // worked out side by side and merged at the end.
    always_comb begin
        col_part = v_q;
        if (strobe.load_x) begin
            col_part = take_horizontal(v_q, t_q);
        end else if (strobe.step_x) begin
            col_part = step_column(v_q);
        end

        row_part = v_q;
        if (strobe.load_y) begin
            row_part = take_vertical(v_q, t_q);
        end else if (strobe.step_y) begin
            row_part = step_row(v_q);
        end

        v_d = take_vertical(col_part, row_part);
    end

endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
    import scroll_pkg::*;
#(
    parameter int LINE_W         = 9,
    parameter int DOT_W          = 9,
    parameter int VISIBLE_LINES  = 240,
    parameter int PRE_LINE       = 261,
    parameter int TILE_PIXELS    = 8,
    parameter int FETCH_FIRST    = 8,
    parameter int FETCH_LAST     = 256,
    parameter int PREFETCH_FIRST = 328,
    parameter int PREFETCH_LAST  = 336,
    parameter int ROW_STEP_DOT   = 256,
    parameter int COL_LOAD_DOT   = 257,
    parameter int ROW_LOAD_FIRST = 280,
    parameter int ROW_LOAD_LAST  = 304
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              render_en,
    input  logic [LINE_W-1:0] scanline,
    input  logic [DOT_W-1:0]  dot,
    input  logic              t_wr_en,
    input  logic [ADDR_W-1:0] t_wr_data,
    output logic [ADDR_W-1:0] v_addr
);

    strobe_t strobe;
    vaddr_t  t_q;
    vaddr_t  v_q;
    vaddr_t  v_d;

    scroll_event_decode #(
        .LINE_W        (LINE_W),
        .DOT_W         (DOT_W),
        .VISIBLE_LINES (VISIBLE_LINES),
        .PRE_LINE      (PRE_LINE),
        .TILE_PIXELS   (TILE_PIXELS),
        .FETCH_FIRST   (FETCH_FIRST),
        .FETCH_LAST    (FETCH_LAST),
        .PREFETCH_FIRST(PREFETCH_FIRST),
        .PREFETCH_LAST (PREFETCH_LAST),
        .ROW_STEP_DOT  (ROW_STEP_DOT),
        .COL_LOAD_DOT  (COL_LOAD_DOT),
        .ROW_LOAD_FIRST(ROW_LOAD_FIRST),
        .ROW_LOAD_LAST (ROW_LOAD_LAST)
    ) decode_i (
        .render_en(render_en),
        .scanline (scanline),
        .dot      (dot),
        .strobe   (strobe)
    );

    scroll_temp_reg temp_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (t_wr_en),
        .wr_data(t_wr_data),
        .t_q    (t_q)
    );

    scroll_vaddr_next next_i (
        .v_q   (v_q),
        .t_q   (t_q),
        .strobe(strobe),
        .v_d   (v_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    assign v_addr = v_q;

endmodule

// File: rtl/scroll_addr_chk.sv
module scroll_addr_chk #(
    parameter int LINE_W = 9,
    parameter int DOT_W  = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              render_en,
    input logic [LINE_W-1:0] scanline,
    input logic [DOT_W-1:0]  dot,
    input logic [14:0]       v_addr,
    input logic [14:0]       t_q
);

    logic rline;
    assign rline = (scanline < LINE_W'(240)) || (scanline == LINE_W'(261));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (v_addr == '0) && (t_q == '0));

    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !render_en |=> $stable(v_addr));

    // R10
    idle_lines_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((scanline >= LINE_W'(240)) && (scanline <= LINE_W'(260))) |=> $stable(v_addr));

    // R7
    col_load_chk: assert property (@(posedge clk) disable iff (rst)
        (render_en && rline && dot == DOT_W'(257))
        |=> (v_addr[4:0] == $past(t_q[4:0])) && (v_addr[10] == $past(t_q[10]))
            && (v_addr[14:11] == $past(v_addr[14:11])) && (v_addr[9:5] == $past(v_addr[9:5])));

    // R8
    row_load_chk: assert property (@(posedge clk) disable iff (rst)
        (render_en && scanline == LINE_W'(261) && dot >= DOT_W'(280) && dot <= DOT_W'(304))
        |=> (v_addr[14:11] == $past(t_q[14:11])) && (v_addr[9:5] == $past(t_q[9:5]))
            && (v_addr[10] == $past(v_addr[10])) && (v_addr[4:0] == $past(v_addr[4:0])));

    // R4
    fine_step_chk: assert property (@(posedge clk) disable iff (rst)
        (render_en && rline && dot == DOT_W'(256) && v_addr[14:12] != 3'd7)
        |=> (v_addr[14:12] == $past(v_addr[14:12]) + 3'd1) && (v_addr[9:5] == $past(v_addr[9:5])));

    // R6
    row_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (render_en && rline && dot == DOT_W'(256) && v_addr[14:12] == 3'd7 && v_addr[9:5] == 5'd31)
        |=> (v_addr[9:5] == 5'd0) && (v_addr[11] == $past(v_addr[11])));

endmodule

bind scroll_addr_unit scroll_addr_chk #(
    .LINE_W(LINE_W),
    .DOT_W (DOT_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .render_en(render_en),
    .scanline (scanline),
    .dot      (dot),
    .v_addr   (v_addr),
    .t_q      (t_q)
);

// File: tb/scroll_addr_unit_tb.sv
module scroll_addr_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 24;

    typedef struct packed {
        logic        wr;
        logic [14:0] tdata;
        logic        ren;
        logic [8:0]  line;
        logic [8:0]  dot;
        logic [14:0] expv;
        logic [3:0]  req;
    } vec_t;

    // Rows are applied in order; each expected value follows from the rows before it.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 15'h7BBF, 1'b1, 9'd100, 9'd0,   15'h0000, 4'd2},  // R2 load, no event
        '{1'b0, 15'h0000, 1'b1, 9'd261, 9'd280, 15'h7BA0, 4'd8},  // R8 first copy dot
        '{1'b0, 15'h0000, 1'b1, 9'd261, 9'd257, 15'h7BBF, 4'd7},  // R7
        '{1'b0, 15'h0000, 1'b1, 9'd0,   9'd256, 15'h0400, 4'd5},  // R5 row 29 wrap, R3 col 31 wrap
        '{1'b0, 15'h0000, 1'b0, 9'd0,   9'd256, 15'h0400, 4'd9},  // R9
        '{1'b0, 15'h0000, 1'b1, 9'd0,   9'd8,   15'h0401, 4'd3},  // R3 first fetch dot
        '{1'b0, 15'h0000, 1'b1, 9'd0,   9'd9,   15'h0401, 4'd3},  // R3 not a tile edge
        '{1'b0, 15'h0000, 1'b1, 9'd0,   9'd256, 15'h1402, 4'd4},  // R4
        '{1'b0, 15'h0000, 1'b1, 9'd240, 9'd256, 15'h1402, 4'd10}, // R10
        '{1'b0, 15'h0000, 1'b1, 9'd0,   9'd328, 15'h1403, 4'd3},  // R3 prefetch window
        '{1'b0, 15'h0000, 1'b1, 9'd0,   9'd264, 15'h1403, 4'd3},  // R3 outside windows
        '{1'b1, 15'h0000, 1'b1, 9'd261, 9'd304, 15'h7FA3, 4'd2},  // R2 copy uses old t, R8 last dot
        '{1'b0, 15'h0000, 1'b1, 9'd261, 9'd305, 15'h7FA3, 4'd8},  // R8 past window
        '{1'b0, 15'h0000, 1'b1, 9'd261, 9'd257, 15'h7BA0, 4'd7},  // R7 new t
        '{1'b0, 15'h0000, 1'b1, 9'd261, 9'd279, 15'h7BA0, 4'd8},  // R8 before window
        '{1'b1, 15'h73E0, 1'b0, 9'd261, 9'd280, 15'h7BA0, 4'd9},  // R9 copy suppressed
        '{1'b0, 15'h0000, 1'b1, 9'd261, 9'd280, 15'h73E0, 4'd8},  // R8
        '{1'b0, 15'h0000, 1'b1, 9'd5,   9'd256, 15'h0001, 4'd6},  // R6 row 31 wrap, no flip
        '{1'b1, 15'h70A0, 1'b1, 9'd100, 9'd0,   15'h0001, 4'd2},  // R2 load
        '{1'b0, 15'h0000, 1'b1, 9'd261, 9'd290, 15'h70A1, 4'd8},  // R8 mid window
        '{1'b0, 15'h0000, 1'b1, 9'd261, 9'd256, 15'h00C2, 4'd5},  // R5 plain row carry
        '{1'b0, 15'h0000, 1'b1, 9'd261, 9'd336, 15'h00C3, 4'd3},  // R3 last prefetch dot
        '{1'b0, 15'h0000, 1'b1, 9'd250, 9'd257, 15'h00C3, 4'd10}, // R10 no copy
        '{1'b0, 15'h0000, 1'b1, 9'd250, 9'd8,   15'h00C3, 4'd10}  // R10 no step
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        render_en = 1'b0;
    logic [8:0]  scanline = '0;
    logic [8:0]  dot = '0;
    logic        t_wr_en = 1'b0;
    logic [14:0] t_wr_data = '0;
    logic [14:0] v_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scroll_addr_unit dut_i (
        .clk      (clk),
        .rst      (rst),
        .render_en(render_en),
        .scanline (scanline),
        .dot      (dot),
        .t_wr_en  (t_wr_en),
        .t_wr_data(t_wr_data),
        .v_addr   (v_addr)
    );

    task automatic check(input int req, input logic [14:0] expv);
        n_checks++;
        if (v_addr !== expv) begin
            n_fail++;
            $display("FAIL R%0d: v_addr actual %h expected %h", req, v_addr, expv);
        end
    endtask

    task automatic apply(input logic wr, input logic [14:0] td, input logic ren,
                         input logic [8:0] ln, input logic [8:0] dt);
        @(negedge clk);
        t_wr_en   = wr;
        t_wr_data = td;
        render_en = ren;
        scanline  = ln;
        dot       = dt;
        @(posedge clk);
        #1;
        t_wr_en   = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(1, 15'h0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].wr, VECS[i].tdata, VECS[i].ren, VECS[i].line, VECS[i].dot);
            check(int'(VECS[i].req), VECS[i].expv);
        end

        // R1 reset mid-run clears v and t
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(1, 15'h0000);
        @(negedge clk);
        rst = 1'b0;
        // R1 staging word was cleared: a vertical copy yields zero
        apply(1'b0, 15'h0000, 1'b1, 9'd261, 9'd280);
        check(1, 15'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule